// File: doc/BRIEF.md
# Access Permission Check and Fault Recorder

This block decides, in the same cycle, whether a memory access may proceed, and keeps a record of the most recent translation fault. An access byte comes from a segment or page descriptor. It holds four 2-bit permission fields, one for each CPU execution level. The block takes the field that belongs to the current level and judges the requested access type against it. The result appears on `allow` without a register in the path.

Faults come from two places. A permission check that fails raises the access-denied cause internally. Other causes, such as a missing segment or a length violation, are detected elsewhere and arrive on a strobe with their cause code. The external strobe wins when both happen in one cycle.

When capture is enabled, the fault is written into two registers on the next clock edge. One register holds the fault word, made of the access type, the level and the cause. The other holds the faulting virtual address. A one-bit select reads either register back through a small read port.

Top module: `acc_guard`

## Requirements
- R1: The permission field for level L is acc_byte bits [7-2L:6-2L]. Level 0 uses bits 7:6 and level 3 uses bits 1:0.
- R2: A permission field of 0 makes `allow` low for every access type.
- R3: A permission field of 1 makes `allow` high only for access types 3 (instruction fetch) and 4 (instruction fetch after a jump).
- R4: A permission field of 2 makes `allow` high only for access types 0 (address fetch), 1 (operand fetch), 3, 4 and 5 (memory test). It is low for type 2 (write) and for types 6 to 15 (generic reads).
- R5: A permission field of 3 makes `allow` high for all 16 access types.
- R6: A check with `req_valid` high, `allow` low, `capture_en` high and no external strobe loads two registers on the next edge:
  - the fault word, equal to (acc_type << 7) | (level << 5) | 0x0D, zero-extended to 32 bits;
  - the fault address register, equal to `vaddr`.
- R7: `ext_fault_vld` with `capture_en` high loads the fault word (acc_type << 7) | (level << 5) | ext_cause and loads `vaddr`. This holds for any cause code, including 0x03 to 0x0A and 0x0E. The external cause takes priority over a same-cycle denial.
- R8: With `capture_en` low, neither register changes, whatever the faults. `allow` is still produced.
- R9: After reset, both registers read zero.
- R10: With `capture_en` high, no register changes in either of these cases:
  - an allowed check with no external strobe;
  - `req_valid` low with no external strobe.
- R11: `rd_data` shows the fault word when `rd_sel` is 0 and the fault address when `rd_sel` is 1, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A permission check is requested this cycle |
| acc_byte | input | 8 | Descriptor access byte, four 2-bit permission fields |
| level | input | 2 | Current CPU execution level |
| acc_type | input | 4 | Requested access type |
| vaddr | input | 32 | Virtual address of the access |
| capture_en | input | 1 | Enables recording of faults |
| ext_fault_vld | input | 1 | Strobe for an externally detected fault |
| ext_cause | input | 5 | Cause code of the external fault |
| rd_sel | input | 1 | Read select: 0 = fault word, 1 = fault address |
| allow | output | 1 | Permission check result |
| rd_data | output | 32 | Selected fault register |

## Verification
Two things can happen in the same cycle: a permission denial and an external fault strobe. The bench provokes this by driving a denying access byte and the strobe on one edge. It judges the result by reading the fault word back and confirming that it carries the external cause, not 0x0D. `allow` must still be low for the same request. Around that case, an exhaustive sweep covers every access byte, level and access type against an arithmetic model. Each cause code is then recorded with its own type and level.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_EXEC = 2'd1,
    PERM_READ = 2'd2,
    PERM_FULL = 2'd3
  } perm_e;

  localparam logic [3:0] AT_ADDR_FETCH = 4'd0;
  localparam logic [3:0] AT_OPND_FETCH = 4'd1;
  localparam logic [3:0] AT_WRITE      = 4'd2;
  localparam logic [3:0] AT_INSN_FETCH = 4'd3;
  localparam logic [3:0] AT_INSN_JUMP  = 4'd4;
  localparam logic [3:0] AT_MEM_TEST   = 4'd5;

  localparam logic [4:0] CAUSE_DENIED  = 5'h0D;

endpackage

// File: rtl/acc_perm_pick.sv
module acc_perm_pick #(
  parameter int LVL_W = 2,
  parameter int FLD_W = 2,
  localparam int NLVL  = 1 << LVL_W,
  localparam int ACC_W = FLD_W * NLVL
) (
  input  logic [ACC_W-1:0] acc_byte,
  input  logic [LVL_W-1:0] level,
  output logic [FLD_W-1:0] field
);

  logic [FLD_W-1:0] fld_by_lvl [NLVL];

  // Level 0 owns the most significant field, the highest level the least.
  for (genvar g = 0; g < NLVL; g++) begin : g_fld
    assign fld_by_lvl[g] = acc_byte[(NLVL-1-g)*FLD_W +: FLD_W];
  end

  assign field = fld_by_lvl[level];

endmodule

// File: rtl/acc_perm_judge.sv
module acc_perm_judge
  import acc_guard_pkg::*;
#(
  parameter int TYPE_W = 4
) (
  input  logic [1:0]        field,
  input  logic [TYPE_W-1:0] acc_type,
  output logic              allow
);

  logic is_insn;
  logic is_readish;

  always_comb begin
    is_insn    = (acc_type == TYPE_W'(AT_INSN_FETCH)) ||
                 (acc_type == TYPE_W'(AT_INSN_JUMP));
    is_readish = is_insn ||
                 (acc_type == TYPE_W'(AT_ADDR_FETCH)) ||
                 (acc_type == TYPE_W'(AT_OPND_FETCH)) ||
                 (acc_type == TYPE_W'(AT_MEM_TEST));
    unique case (perm_e'(field))
      PERM_NONE: allow = 1'b0;
      PERM_EXEC: allow = is_insn;
      PERM_READ: allow = is_readish;
      PERM_FULL: allow = 1'b1;
      default:   allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_fault_pick.sv
module acc_fault_pick
  import acc_guard_pkg::*;
#(
  parameter int TYPE_W  = 4,
  parameter int LVL_W   = 2,
  parameter int CAUSE_W = 5,
  parameter int REG_W   = 32,
  localparam int PAD_W  = REG_W - TYPE_W - LVL_W - CAUSE_W
) (
  input  logic               req_valid,
  input  logic               allow,
  input  logic               capture_en,
  input  logic               ext_fault_vld,
  input  logic [CAUSE_W-1:0] ext_cause,
  input  logic [TYPE_W-1:0]  acc_type,
  input  logic [LVL_W-1:0]   level,
  output logic               rec_en,
  output logic [REG_W-1:0]   code_d
);

  logic               deny_evt;
  logic [CAUSE_W-1:0] cause;

  always_comb begin
    deny_evt = req_valid && !allow;
    cause    = ext_fault_vld ? ext_cause : CAUSE_W'(CAUSE_DENIED);
    rec_en   = capture_en && (ext_fault_vld || deny_evt);
    code_d   = {{PAD_W{1'b0}}, acc_type, level, cause};
  end

endmodule

// File: rtl/acc_fault_store.sv
module acc_fault_store #(
  parameter int REG_W = 32,
  parameter int VA_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_en,
  input  logic [REG_W-1:0] code_d,
  input  logic [VA_W-1:0]  addr_d,
  output logic [REG_W-1:0] code_q,
  output logic [VA_W-1:0]  addr_q
);

  logic [REG_W-1:0] code_n;
  logic [VA_W-1:0]  addr_n;

  always_comb begin
    code_n = code_q;
    addr_n = addr_q;
    if (rec_en) begin
      code_n = code_d;
      addr_n = addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      addr_q <= '0;
    end else begin
      code_q <= code_n;
      addr_q <= addr_n;
    end
  end

endmodule

// File: rtl/acc_guard.sv
module acc_guard #(
  parameter int VA_W    = 32,
  parameter int REG_W   = 32,
  parameter int TYPE_W  = 4,
  parameter int LVL_W   = 2,
  parameter int CAUSE_W = 5,
  parameter int SYNC_N  = 2,
  localparam int FLD_W  = 2,
  localparam int ACC_W  = FLD_W << LVL_W,
  localparam int RD_W   = (REG_W > VA_W) ? REG_W : VA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ACC_W-1:0]   acc_byte,
  input  logic [LVL_W-1:0]   level,
  input  logic [TYPE_W-1:0]  acc_type,
  input  logic [VA_W-1:0]    vaddr,
  input  logic               capture_en,
  input  logic               ext_fault_vld,
  input  logic [CAUSE_W-1:0] ext_cause,
  input  logic               rd_sel,
  output logic               allow,
  output logic [RD_W-1:0]    rd_data
);

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sync_n;
  logic [FLD_W-1:0]  field;
  logic              rec_en;
  logic [REG_W-1:0]  code_d;
  logic [REG_W-1:0]  code_q;
  logic [VA_W-1:0]   addr_q;

  // Reset asserts at once and is released after SYNC_N clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  acc_perm_pick #(.LVL_W(LVL_W), .FLD_W(FLD_W)) u_pick (
    .acc_byte (acc_byte),
    .level    (level),
    .field    (field)
  );

  acc_perm_judge #(.TYPE_W(TYPE_W)) u_judge (
    .field    (field),
    .acc_type (acc_type),
    .allow    (allow)
  );

  acc_fault_pick #(
    .TYPE_W(TYPE_W), .LVL_W(LVL_W), .CAUSE_W(CAUSE_W), .REG_W(REG_W)
  ) u_fpick (
    .req_valid     (req_valid),
    .allow         (allow),
    .capture_en    (capture_en),
    .ext_fault_vld (ext_fault_vld),
    .ext_cause     (ext_cause),
    .acc_type      (acc_type),
    .level         (level),
    .rec_en        (rec_en),
    .code_d        (code_d)
  );

  acc_fault_store #(.REG_W(REG_W), .VA_W(VA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rec_en (rec_en),
    .code_d (code_d),
    .addr_d (vaddr),
    .code_q (code_q),
    .addr_q (addr_q)
  );

  always_comb begin
    rd_data = rd_sel ? RD_W'(addr_q) : RD_W'(code_q);
  end

endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk #(
  parameter int VA_W    = 32,
  parameter int REG_W   = 32,
  parameter int TYPE_W  = 4,
  parameter int LVL_W   = 2,
  parameter int CAUSE_W = 5,
  localparam int ACC_W  = 2 << LVL_W,
  localparam int PAD_W  = REG_W - TYPE_W - LVL_W - CAUSE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [ACC_W-1:0]   acc_byte,
  input logic [LVL_W-1:0]   level,
  input logic [TYPE_W-1:0]  acc_type,
  input logic [VA_W-1:0]    vaddr,
  input logic               capture_en,
  input logic               ext_fault_vld,
  input logic [CAUSE_W-1:0] ext_cause,
  input logic               allow,
  input logic [REG_W-1:0]   code_q,
  input logic [VA_W-1:0]    addr_q
);

  p_level0_top_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && acc_byte[ACC_W-1 -: 2] == 2'b11) |-> allow);

  p_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '1 && acc_byte[1:0] == 2'b00) |-> !allow);

  p_read_only_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '1 && acc_byte[1:0] == 2'b10 && acc_type == TYPE_W'(2)) |-> !allow);

  p_deny_logged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !allow && capture_en && !ext_fault_vld) |=>
      (code_q == {{PAD_W{1'b0}}, $past(acc_type), $past(level), CAUSE_W'(5'h0D)}
       && addr_q == $past(vaddr)));

  p_ext_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fault_vld && capture_en) |=>
      (code_q[CAUSE_W-1:0] == $past(ext_cause) && addr_q == $past(vaddr)));

  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en |=> ($stable(code_q) && $stable(addr_q)));

  p_hold_when_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && !ext_fault_vld && (!req_valid || allow)) |=>
      ($stable(code_q) && $stable(addr_q)));

endmodule

bind acc_guard acc_guard_chk #(
  .VA_W(VA_W), .REG_W(REG_W), .TYPE_W(TYPE_W), .LVL_W(LVL_W), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .acc_byte      (acc_byte),
  .level         (level),
  .acc_type      (acc_type),
  .vaddr         (vaddr),
  .capture_en    (capture_en),
  .ext_fault_vld (ext_fault_vld),
  .ext_cause     (ext_cause),
  .allow         (allow),
  .code_q        (code_q),
  .addr_q        (addr_q)
);

// File: tb/acc_guard_test.sv
module acc_guard_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  acc_byte;
  logic [1:0]  level;
  logic [3:0]  acc_type;
  logic [31:0] vaddr;
  logic        capture_en;
  logic        ext_fault_vld;
  logic [4:0]  ext_cause;
  logic        rd_sel;
  logic        allow;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  acc_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_byte(acc_byte),
    .level(level), .acc_type(acc_type), .vaddr(vaddr), .capture_en(capture_en),
    .ext_fault_vld(ext_fault_vld), .ext_cause(ext_cause), .rd_sel(rd_sel),
    .allow(allow), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_allow(int a, int l, int t);
    int p;
    p = (a >> ((3 - l) * 2)) & 3;
    case (p)
      0: return 1'b0;
      1: return (t == 3 || t == 4);
      2: return (t == 0 || t == 1 || t == 3 || t == 4 || t == 5);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] exp_code(int t, int l, int c);
    return 32'((t << 7) | (l << 5) | c);
  endfunction

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_regs(string tag, logic [31:0] code, logic [31:0] addr);
    rd_sel = 1'b0;
    #1;
    check_val({tag, " code"}, rd_data, code);
    rd_sel = 1'b1;
    #1;
    check_val({tag, " addr"}, rd_data, addr);
    rd_sel = 1'b0;
  endtask

  task automatic go_idle();
    req_valid = 0; capture_en = 0; ext_fault_vld = 0; ext_cause = '0;
  endtask

  // Drive one cycle of stimulus, check allow, let the edge pass, go idle.
  task automatic one_shot(bit rv, int a, int l, int t, logic [31:0] va, bit cap,
                          bit ev, int ec, string tag);
    @(negedge clk);
    req_valid = rv; acc_byte = 8'(a); level = 2'(l); acc_type = 4'(t);
    vaddr = va; capture_en = cap; ext_fault_vld = ev; ext_cause = 5'(ec);
    #1;
    check_val({tag, " allow"}, {31'b0, allow}, {31'b0, exp_allow(a, l, t)});
    @(negedge clk);
    go_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cause_list[10] = '{3, 4, 5, 6, 7, 8, 9, 10, 13, 14};
    logic [31:0] cur_code, cur_addr;
    rst_n = 0; rd_sel = 0; acc_byte = 0; level = 0; acc_type = 0; vaddr = 0;
    go_idle();
    repeat (4) @(negedge clk);
    // R9: registers are zero while and after reset
    check_regs("R9 in reset", 32'h0, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_regs("R9 after reset", 32'h0, 32'h0);

    // R1..R5: exhaustive sweep of byte, level and type, capture off
    req_valid = 1;
    for (int a = 0; a < 256; a++) begin
      for (int l = 0; l < 4; l++) begin
        for (int t = 0; t < 16; t++) begin
          int p;
          string tag;
          p = (a >> ((3 - l) * 2)) & 3;
          case (p)
            0: tag = "R1/R2";
            1: tag = "R1/R3";
            2: tag = "R1/R4";
            default: tag = "R1/R5";
          endcase
          @(negedge clk);
          acc_byte = 8'(a); level = 2'(l); acc_type = 4'(t);
          #1;
          checks++;
          if (allow !== exp_allow(a, l, t)) begin
            errors++;
            $display("FAIL %s byte=%0h lvl=%0d type=%0d: actual %0b expected %0b",
                     tag, a, l, t, allow, exp_allow(a, l, t));
          end
        end
      end
    end
    @(negedge clk);
    go_idle();
    #1;
    // R8: a sweep full of denials with capture off left nothing behind
    check_regs("R8 after sweep", 32'h0, 32'h0);

    // R6: denied write at level 0 recorded with cause 0x0D
    one_shot(1, 8'h00, 0, 2, 32'h8000_1234, 1, 0, 0, "R6");
    check_regs("R6", exp_code(2, 0, 13), 32'h8000_1234);

    // R7: external fault on an allowed access
    one_shot(1, 8'hFF, 3, 1, 32'h0001_F800, 1, 1, 7, "R7 ext");
    check_regs("R7 ext", exp_code(1, 3, 7), 32'h0001_F800);

    // R7: external strobe and denial in the same cycle, external wins
    one_shot(1, 8'h00, 2, 2, 32'hC000_0040, 1, 1, 10, "R7 both");
    check_regs("R7 both", exp_code(2, 2, 10), 32'hC000_0040);

    // R8: denial with capture off, allow still low, registers held
    one_shot(1, 8'h00, 1, 2, 32'h1111_1111, 0, 0, 0, "R8 deny");
    check_regs("R8 deny", exp_code(2, 2, 10), 32'hC000_0040);
    one_shot(1, 8'hFF, 1, 0, 32'h2222_2222, 0, 1, 6, "R8 ext");
    check_regs("R8 ext", exp_code(2, 2, 10), 32'hC000_0040);

    // R10: allowed check and idle request with capture on, nothing recorded
    one_shot(1, 8'h55, 3, 3, 32'h3333_3333, 1, 0, 0, "R10 allowed");
    check_regs("R10 allowed", exp_code(2, 2, 10), 32'hC000_0040);
    one_shot(0, 8'h00, 0, 2, 32'h4444_4444, 1, 0, 0, "R10 no req");
    check_regs("R10 no req", exp_code(2, 2, 10), 32'hC000_0040);

    // R7: every cause code with its own type and level
    foreach (cause_list[i]) begin
      int t, l;
      t = (i * 3) % 16;
      l = i % 4;
      cur_addr = 32'h0100_0000 * 32'(i + 1) + 32'(i);
      cur_code = exp_code(t, l, cause_list[i]);
      one_shot(0, 8'hFF, l, t, cur_addr, 1, 1, cause_list[i], "R7 cause");
      check_regs("R7 cause", cur_code, cur_addr);
    end

    // R11: read select switches without a clock edge
    rd_sel = 1'b1;
    #1;
    cur_addr = rd_data;
    rd_sel = 1'b0;
    #1;
    check_val("R11 sel0", rd_data, exp_code(27 % 16, 1, 14));
    check_val("R11 sel1", cur_addr, 32'h0A00_0009);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule